// File: doc/BRIEF.md
# Six-Stage Pipelined Integer Add Core

This block is a small in-order 32-bit integer pipeline that executes a single operation: register-register addition. An instruction moves through six stages. In the address stage the program counter is stepped. In the fetch stage the instruction word is captured. In the decode stage the two sources are read from the register file. The execute stage adds the operands. The memory stage only carries the sum forward. In the writeback stage the sum is written to the destination register. The instruction memory sits outside the block. It receives the program counter and must present the addressed word within the same cycle, so that the word is registered at the next edge.

There are no forwarding paths. A read-after-write hazard is handled by an interlock. When either nonzero source register of the instruction in decode matches the destination held in execute, memory or writeback, the interlock freezes the program counter and the fetched word, and it feeds an empty slot into execute. The register file has two combinational read ports. When a read address equals the address being written in the same cycle, the port returns the incoming write data. A debug port lets a bench or a tool load any register and read back its stored value.

Top module: `add_pipe_core`

## Requirements
- R1: The program counter resets to 0x80000000 and advances by 4 on every clock edge at which no stall is flagged. The `imem_addr` port shows the program counter.
- R2: While `stall` is high, the program counter and the registered instruction word both keep their values.
- R3: The word on `imem_data` during a cycle is registered as the instruction in decode at the next rising edge, provided no stall is flagged.
- R4: An add whose address is on `imem_addr` in the first cycle after reset writes rd = rs1 + rs2 (mod 2^32) at the fifth rising edge. The instruction fields are opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20] and funct7 [31:25].
- R5: Register 0 always reads as zero. Writes to register 0 are discarded, whether they come from the pipeline or from the debug port.
- R6: Only a word with opcode 0110011, funct3 000 and funct7 0000000 writes a register. Any other word, including other register-register encodings and immediate forms, leaves every register unchanged.
- R7: `stall` is high exactly when rs1 or rs2 of the word in decode is nonzero and equals the destination in execute, memory or writeback. An add that depends on the add immediately before it therefore waits 3 cycles. Instructions without a dependence never stall.
- R8: During a stall an empty slot (opcode 0, rd 0) enters execute, so that the held instruction takes effect exactly once.
- R9: When `dbg_we` is high, `dbg_wdata` is written to register `dbg_addr` at the rising edge. A writeback in the same cycle takes priority. `dbg_rdata` combinationally shows the stored value of register `dbg_addr`.
- R10: While `rst_n` is low, the program counter returns at once to 0x80000000, `stall` is low and every pipeline stage is empty. Register contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction address (program counter) |
| imem_data | input | 32 | Instruction word for imem_addr, valid in the same cycle |
| dbg_we | input | 1 | Debug register write enable |
| dbg_addr | input | 5 | Debug register index for read and write |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Stored value of register dbg_addr |
| stall | output | 1 | Read-after-write interlock active |

## Verification
Counting from the cycle in which an instruction's address is first shown, its word lands in decode after one edge. Its operands reach execute after two edges, the sum after three, the writeback value after four, and the register is updated at the fifth edge. A dependent instruction adds three cycles of stall for each hazard. The bench releases reset on a falling edge and samples only on falling edges. Each falling edge is numbered by the rising edges before it. The destination register of the first add is read on edge 4, when it must still hold its preload, and again on edge 5, when it must hold the sum. The program counter is checked on edges 1 and 4, against the frozen value during a stall. After each program has drained, all 32 registers are compared with a sequential model in the bench, and the stall count is compared with the number of hazard cycles worked out from the program.

// File: rtl/add_core_pkg.sv
package add_core_pkg;

  localparam int unsigned REG_AW = 5;
  localparam int unsigned IW     = 32;

  localparam logic [6:0] OPC_REG_ALU = 7'b0110011;
  localparam logic [2:0] F3_ADD      = 3'b000;
  localparam logic [6:0] F7_ADD      = 7'b0000000;

  typedef struct packed {
    logic [6:0]        f7;
    logic [REG_AW-1:0] rs2;
    logic [REG_AW-1:0] rs1;
    logic [2:0]        f3;
    logic [REG_AW-1:0] rd;
    logic [6:0]        opc;
  } insn_t;

  function automatic logic [31:0] wrap_add(input logic [31:0] a, input logic [31:0] b);
    return a + b;
  endfunction

  function automatic logic src_hits(input logic [REG_AW-1:0] src,
                                    input logic [REG_AW-1:0] ex_rd,
                                    input logic [REG_AW-1:0] mem_rd,
                                    input logic [REG_AW-1:0] wb_rd);
    return (src != '0) && ((src == ex_rd) || (src == mem_rd) || (src == wb_rd));
  endfunction

  function automatic logic is_add_word(input insn_t w);
    return (w.opc == OPC_REG_ALU) && (w.f3 == F3_ADD) && (w.f7 == F7_ADD);
  endfunction

endpackage

// File: rtl/add_pc_unit.sv
module add_pc_unit #(
  parameter int unsigned XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;

  always_comb pc_next = step_en ? pc_q + STEP : pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  assign pc = pc_q;

  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc_q == $past(pc_q) + STEP);

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));

endmodule

// File: rtl/add_fetch_reg.sv
module add_fetch_reg #(
  parameter int unsigned IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [IW-1:0] mem_word,
  output logic [IW-1:0] ir
);
  logic [IW-1:0] ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (!hold) ir_q <= mem_word;
  end

  assign ir = ir_q;

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(ir_q));

  assert_ir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> ir_q == $past(mem_word));

endmodule

// File: rtl/add_regfile.sv
module add_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32
) (
  input  logic                    clk,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [XLEN-1:0]         rd1,
  output logic [XLEN-1:0]         rd2,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [XLEN-1:0]         wd,
  input  logic                    dbg_we,
  input  logic [$clog2(NREG)-1:0] dbg_a,
  input  logic [XLEN-1:0]         dbg_wd,
  output logic [XLEN-1:0]         dbg_rd
);
  localparam int unsigned AW = $clog2(NREG);

  logic [XLEN-1:0] store [1:NREG-1];

  always_ff @(posedge clk) begin
    if (wa != '0)                     store[wa]    <= wd;
    else if (dbg_we && dbg_a != '0)   store[dbg_a] <= dbg_wd;
  end

  always_comb begin
    if (ra1 == '0)      rd1 = '0;
    else if (ra1 == wa) rd1 = wd;
    else                rd1 = store[ra1];
    if (ra2 == '0)      rd2 = '0;
    else if (ra2 == wa) rd2 = wd;
    else                rd2 = store[ra2];
    if (dbg_a == AW'(0)) dbg_rd = '0;
    else                 dbg_rd = store[dbg_a];
  end

endmodule

// File: rtl/add_decode.sv
module add_decode
  import add_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     ir,
  output logic [REG_AW-1:0] rs1_sel,
  output logic [REG_AW-1:0] rs2_sel,
  output logic              stall,
  output logic [REG_AW-1:0] wb_rd
);
  insn_t             word;
  logic [REG_AW-1:0] d_rd;
  logic [6:0]        x_op, m_op, w_op;
  logic [REG_AW-1:0] x_rd, m_rd, w_rd;
  logic              hit1, hit2;

  assign word    = insn_t'(ir);
  assign rs1_sel = word.rs1;
  assign rs2_sel = word.rs2;
  assign d_rd    = is_add_word(word) ? word.rd : '0;

  assign hit1  = src_hits(word.rs1, x_rd, m_rd, w_rd);
  assign hit2  = src_hits(word.rs2, x_rd, m_rd, w_rd);
  assign stall = hit1 | hit2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_op <= '0; x_rd <= '0;
      m_op <= '0; m_rd <= '0;
      w_op <= '0; w_rd <= '0;
    end else begin
      if (stall) begin
        x_op <= '0;
        x_rd <= '0;
      end else begin
        x_op <= word.opc;
        x_rd <= d_rd;
      end
      m_op <= x_op; m_rd <= x_rd;
      w_op <= m_op; w_rd <= m_rd;
    end
  end

  assign wb_rd = (w_op == OPC_REG_ALU) ? w_rd : '0;

  assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (x_op == '0) && (x_rd == '0));

  assert_wb_only_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_rd != '0) |-> (w_op == OPC_REG_ALU));

  assert_rd_travels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd != '0) |=> ##1 (w_rd == $past(x_rd, 2)));

endmodule

// File: rtl/add_datapath.sv
module add_datapath
  import add_core_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] wb_val
);
  logic [XLEN-1:0] x_a, x_b, m_sum, w_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_a <= '0; x_b <= '0; m_sum <= '0; w_val <= '0;
    end else begin
      x_a   <= src_a;
      x_b   <= src_b;
      m_sum <= wrap_add(x_a, x_b);
      w_val <= m_sum;
    end
  end

  assign wb_val = w_val;

  assert_add_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ##1 (w_val == $past(x_a, 2) + $past(x_b, 2)));

endmodule

// File: rtl/add_pipe_core.sv
module add_pipe_core
  import add_core_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NREG     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [IW-1:0]   imem_data,
  input  logic            dbg_we,
  input  logic [REG_AW-1:0] dbg_addr,
  input  logic [XLEN-1:0] dbg_wdata,
  output logic [XLEN-1:0] dbg_rdata,
  output logic            stall
);
  logic [IW-1:0]     ir;
  logic [REG_AW-1:0] rs1_sel, rs2_sel, wb_rd;
  logic [XLEN-1:0]   op_a, op_b, wb_val;
  logic              hazard;

  add_pc_unit #(.XLEN(XLEN), .RESET_PC(RESET_PC)) pc_i (
    .clk(clk), .rst_n(rst_n), .step_en(!hazard), .pc(imem_addr));

  add_fetch_reg #(.IW(IW)) fetch_i (
    .clk(clk), .rst_n(rst_n), .hold(hazard), .mem_word(imem_data), .ir(ir));

  add_decode dec_i (
    .clk(clk), .rst_n(rst_n), .ir(ir), .rs1_sel(rs1_sel), .rs2_sel(rs2_sel),
    .stall(hazard), .wb_rd(wb_rd));

  add_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
    .clk(clk), .ra1(rs1_sel), .ra2(rs2_sel), .rd1(op_a), .rd2(op_b),
    .wa(wb_rd), .wd(wb_val),
    .dbg_we(dbg_we), .dbg_a(dbg_addr), .dbg_wd(dbg_wdata), .dbg_rd(dbg_rdata));

  add_datapath #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rst_n(rst_n), .src_a(op_a), .src_b(op_b), .wb_val(wb_val));

  assign stall = hazard;

  assert_x0_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rs1_sel == '0) |-> (op_a == '0)) and ((rs2_sel == '0) |-> (op_b == '0)));

  assert_x0_debug_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == '0) |-> (dbg_rdata == '0));

endmodule

// File: tb/add_pipe_core_tb_top.sv
module add_pipe_core_tb_top;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dbg_wdata, dbg_rdata;
  logic [4:0]  dbg_addr = '0;
  logic        dbg_we = 1'b0;
  logic        stall;

  logic [31:0] prog  [0:15];
  logic [31:0] model [0:31];
  int plen = 0;
  int checks = 0, errors = 0, nstall = 0;

  always #5 clk = ~clk;

  add_pipe_core dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .stall(stall));

  always_comb begin
    logic [31:0] off;
    off = imem_addr - BASE;
    imem_data = 32'h0;
    if (imem_addr >= BASE && (off >> 2) < 32'(plen)) imem_data = prog[off[5:2]];
  end

  function automatic logic [31:0] enc(input int rd, input int rs1, input int rs2);
    return {7'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
  endfunction

  function automatic logic [31:0] init_val(input int i);
    case (i)
      0: return 32'hDEAD_BEEF;
      1: return 32'd4;   2: return 32'd27;  3: return 32'd0;
      4: return 32'd83;  5: return 32'd29;  6: return 32'd58;
      7: return 32'hFFFF_FFFF; 8: return 32'd2;
      default: return (32'(i) * 32'h1111_1111) ^ 32'hA5A5_A5A5;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sequential reference: only exact add words (opcode 0110011, funct3 0, funct7 0) write.
  task automatic apply_model();
    for (int k = 0; k < plen; k++) begin
      logic [31:0] w;
      w = prog[k];
      if (w[6:0] == 7'b0110011 && w[14:12] == 3'b0 && w[31:25] == 7'b0 && w[11:7] != 5'd0)
        model[w[11:7]] = model[w[19:15]] + model[w[24:20]];
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      if (stall) nstall++;
    end
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    nstall = 0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      dbg_we = 1'b1; dbg_addr = 5'(i); dbg_wdata = init_val(i);
      @(negedge clk);
      model[i] = (i == 0) ? 32'h0 : init_val(i);
    end
    dbg_we = 1'b0;
    dbg_addr = 5'd0; #1;
    check(dbg_rdata == 32'h0, "R5 x0 ignores debug write", dbg_rdata, 32'h0);
    dbg_addr = 5'd7; #1;
    check(dbg_rdata == 32'hFFFF_FFFF, "R9 debug write/read", dbg_rdata, 32'hFFFF_FFFF);
    check(stall == 1'b0, "R10 stall low in reset", 32'(stall), 32'h0);
    check(imem_addr == BASE, "R10 pc in reset", imem_addr, BASE);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(imem_addr == BASE, "R1 pc after reset", imem_addr, BASE);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 32; i++) begin
      dbg_addr = 5'(i); #1;
      check(dbg_rdata == model[i], tag, dbg_rdata, model[i]);
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Test 1: three independent adds
    plen = 3;
    prog[0] = 32'h0000_0133; prog[1] = 32'h0000_81B3; prog[2] = 32'h0042_8333;
    check(enc(2, 0, 0) == 32'h0000_0133, "R4 field layout", enc(2, 0, 0), 32'h0000_0133);
    start_run();
    dbg_addr = 5'd2;
    step(1);
    check(imem_addr == BASE + 32'd4, "R1 pc step", imem_addr, BASE + 32'd4);
    step(3);
    check(dbg_rdata == 32'd27, "R3/R4 not written before edge 5", dbg_rdata, 32'd27);
    step(1);
    check(dbg_rdata == 32'd0, "R3/R4 written at edge 5", dbg_rdata, 32'd0);
    step(20);
    check(nstall == 0, "R7 no false stall", 32'(nstall), 32'd0);
    apply_model();
    check(model[6] == 32'h70 && model[3] == 32'd4, "R4 model sanity", model[6], 32'h70);
    check_regs("R4 program one registers");

    // Test 2: one dependent pair
    plen = 2;
    prog[0] = 32'h0000_0133; prog[1] = 32'h0021_02B3;
    start_run();
    step(1);
    check(imem_addr == BASE + 32'd4, "R1 pc step", imem_addr, BASE + 32'd4);
    step(3);
    check(imem_addr == BASE + 32'd8, "R2 pc frozen during stall", imem_addr, BASE + 32'd8);
    check(stall == 1'b1, "R7 stall raised", 32'(stall), 32'd1);
    step(20);
    check(nstall == 3, "R7 three stall cycles", 32'(nstall), 32'd3);
    apply_model();
    check_regs("R2/R7 program two registers");

    // Test 3: accumulating chain, a repeated issue would change the result (R8)
    plen = 3;
    prog[0] = enc(10, 10, 1); prog[1] = enc(10, 10, 10); prog[2] = enc(10, 10, 1);
    start_run();
    step(30);
    check(nstall == 6, "R8 stall count for chain", 32'(nstall), 32'd6);
    apply_model();
    check_regs("R8 single effect per instruction");

    // Test 4: sweep of independent adds, x0 target, non-add words, wraparound
    plen = 13;
    for (int k = 0; k < 8; k++) prog[k] = enc(14 + k, 1 + k, 8 - k);
    prog[8]  = enc(0, 1, 2);
    prog[9]  = enc(22, 0, 7);
    prog[10] = 32'h0020_8193;
    prog[11] = 32'h4020_8233;
    prog[12] = enc(23, 7, 8);
    start_run();
    step(40);
    check(nstall == 0, "R7 no stall without dependence", 32'(nstall), 32'd0);
    apply_model();
    check(model[23] == 32'd1, "R4 wraparound model", model[23], 32'd1);
    check_regs("R4/R5/R6 sweep registers");

    // Test 5: reset in mid-run
    plen = 2;
    prog[0] = 32'h0000_0133; prog[1] = 32'h0021_02B3;
    start_run();
    step(3);
    rst_n = 1'b0; #1;
    check(imem_addr == BASE, "R10 async pc reset", imem_addr, BASE);
    check(stall == 1'b0, "R10 stall cleared", 32'(stall), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule